// File: doc/BRIEF.md
# Skew Polarity Decision Unit

This block decides, for one time-interleaved sampling channel, whether that channel's clock edge arrives before or after a shared timing reference edge. It is a synchronous, cycle-level model of a pair of cross-locking flip-flops. One pulse input marks the reference edge and another marks the channel edge. Two phase strobes frame each acquisition. The first strobe clears the detector and arms it. The second strobe closes the window.

The first edge to arrive sets its own flag and locks the other flag out until the next clear. `flag_ref` high with `flag_chn` low means the reference was earlier. `flag_chn` high with `flag_ref` low means the channel was earlier. The window can close with no winner, either because no edge came or because both edges came in the same cycle. In that case the block forces the reference-early answer and raises `forced_dec`. Every acquisition therefore ends with exactly one flag set. A one-cycle `dec_valid` pulse tells the downstream delay-code counter that it may take one step in the indicated direction.

Top module: `skew_polarity_det`

## Requirements
- R1: With `rst` high at a clock edge, `flag_ref`, `flag_chn`, `forced_dec` and `dec_valid` are all 0 after that edge.
- R2: When the detector is armed and only `ref_hit` is high in a cycle, the next cycle shows `flag_ref`=1 and `flag_chn`=0, meaning the reference leads.
- R3: When the detector is armed and only `chn_hit` is high in a cycle, the next cycle shows `flag_chn`=1 and `flag_ref`=0, meaning the channel leads.
- R4: Once either flag is set, it stays set and the opposite flag stays 0 until `clr_phase` or `rst`, whatever edge pulses arrive later.
- R5: If `ref_hit` and `chn_hit` are both high in the same armed cycle, neither flag is set.
- R6: While `clr_phase` is high, all three flags are 0 on the next cycle and edge pulses in that cycle are ignored. `clr_phase` takes priority over `close_phase`.
- R7: After `clr_phase` falls, the detector accepts a new first edge in the very next cycle.
- R8: If `close_phase` is high and no flag is set, the next cycle shows `forced_dec`=1, `flag_ref`=1 and `flag_chn`=0. An edge pulse in that same cycle does not change this outcome.
- R9: A forced outcome holds, with edge pulses ignored, until the next `clr_phase`.
- R10: `dec_valid` is 1 for the cycle after each `close_phase` cycle without `clr_phase`, and 0 otherwise. Whenever it is 1, exactly one of the two flags is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_hit | input | 1 | Single-cycle pulse marking the reference edge |
| chn_hit | input | 1 | Single-cycle pulse marking the channel edge |
| clr_phase | input | 1 | Clear strobe; while high, the detector is held empty |
| close_phase | input | 1 | Window-close strobe; resolves the acquisition |
| flag_ref | output | 1 | Reference-was-first flag |
| flag_chn | output | 1 | Channel-was-first flag |
| forced_dec | output | 1 | The acquisition ended without a winner and was forced |
| dec_valid | output | 1 | One-cycle pulse: the flags hold a decision |

## Verification
The bench sends a late opposite edge after a winner is set. A design without lockout would then show both flags or flip the answer. It drives both edges in the same cycle, which exposes a design that favours one side instead of deferring to the forced path. It also fires an edge together with the close strobe, fires edges after a forced result, and asserts the clear and close strobes together. A design with the wrong priorities would lose the forced answer, let it be overwritten, or emit a decision pulse during a clear. Mid-acquisition reset and re-arming straight after a clear are also checked, since a design that holds stale flags would fail them.

// File: rtl/skp_pkg.sv
package skp_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_REF  = 2'd1,
        WIN_CHN  = 2'd2
    } win_e;

    typedef struct packed {
        logic ref_f;
        logic chn_f;
        logic forced;
    } det_state_t;

    localparam det_state_t DET_IDLE   = '{ref_f: 1'b0, chn_f: 1'b0, forced: 1'b0};
    localparam det_state_t DET_FORCED = '{ref_f: 1'b1, chn_f: 1'b0, forced: 1'b1};

    // A lone pulse wins; a tie or silence yields no winner.
    function automatic win_e race(input logic r, input logic c);
        if (r && !c)
            return WIN_REF;
        else if (c && !r)
            return WIN_CHN;
        else
            return WIN_NONE;
    endfunction

    function automatic logic has_winner(input det_state_t s);
        return s.ref_f | s.chn_f;
    endfunction

endpackage

// File: rtl/skp_race.sv
module skp_race
    import skp_pkg::*;
(
    input  logic armed,
    input  logic ref_hit,
    input  logic chn_hit,
    output win_e win
);
    always_comb begin
        if (armed)
            win = race(ref_hit, chn_hit);
        else
            win = WIN_NONE;
    end
endmodule

// File: rtl/skp_force.sv
module skp_force
    import skp_pkg::*;
(
    input  det_state_t cur,
    input  logic       clr_phase,
    input  logic       close_phase,
    output logic       force_req
);
    always_comb begin
        force_req = close_phase && !clr_phase && !cur.forced && !has_winner(cur);
    end
endmodule

// File: rtl/skp_state.sv
module skp_state
    import skp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_phase,
    input  logic       close_phase,
    input  win_e       win,
    input  logic       force_req,
    output det_state_t cur,
    output logic       valid_q
);
    det_state_t nxt;
    logic       valid_d;

    always_comb begin
        nxt = cur;
        if (clr_phase) begin
            nxt = DET_IDLE;
        end else if (force_req) begin
            nxt = DET_FORCED;
        end else begin
            case (win)
                WIN_REF: nxt.ref_f = 1'b1;
                WIN_CHN: nxt.chn_f = 1'b1;
                default: nxt = cur;
            endcase
        end
        valid_d = close_phase && !clr_phase && (nxt.ref_f ^ nxt.chn_f);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= DET_IDLE;
            valid_q <= 1'b0;
        end else begin
            cur     <= nxt;
            valid_q <= valid_d;
        end
    end
endmodule

// File: rtl/skew_polarity_det.sv
module skew_polarity_det
    import skp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ref_hit,
    input  logic chn_hit,
    input  logic clr_phase,
    input  logic close_phase,
    output logic flag_ref,
    output logic flag_chn,
    output logic forced_dec,
    output logic dec_valid
);
    det_state_t cur;
    win_e       win;
    logic       force_req;
    logic       armed;
    logic       valid_q;

    // Edges count only while empty and the window is open.
    assign armed = !clr_phase && !close_phase && !cur.forced && !has_winner(cur);

    skp_race u_race (
        .armed   (armed),
        .ref_hit (ref_hit),
        .chn_hit (chn_hit),
        .win     (win)
    );

    skp_force u_force (
        .cur         (cur),
        .clr_phase   (clr_phase),
        .close_phase (close_phase),
        .force_req   (force_req)
    );

    skp_state u_state (
        .clk         (clk),
        .rst         (rst),
        .clr_phase   (clr_phase),
        .close_phase (close_phase),
        .win         (win),
        .force_req   (force_req),
        .cur         (cur),
        .valid_q     (valid_q)
    );

    assign flag_ref   = cur.ref_f;
    assign flag_chn   = cur.chn_f;
    assign forced_dec = cur.forced;
    assign dec_valid  = valid_q;
endmodule

// File: rtl/skp_checker.sv
module skp_checker (
    input logic clk,
    input logic rst,
    input logic ref_hit,
    input logic chn_hit,
    input logic clr_phase,
    input logic close_phase,
    input logic flag_ref,
    input logic flag_chn,
    input logic forced_dec,
    input logic dec_valid
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!flag_ref && !flag_chn && !forced_dec && !dec_valid));

    // R4
    ref_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_ref && !clr_phase) |=> (flag_ref && !flag_chn));

    // R4
    chn_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_chn && !clr_phase) |=> (flag_chn && !flag_ref));

    // R5
    tie_none_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_hit && chn_hit && !flag_ref && !flag_chn && !clr_phase && !close_phase)
        |=> (!flag_ref && !flag_chn));

    // R6
    clear_hold_chk: assert property (@(posedge clk) disable iff (rst)
        clr_phase |=> (!flag_ref && !flag_chn && !forced_dec));

    // R8
    force_set_chk: assert property (@(posedge clk) disable iff (rst)
        (close_phase && !clr_phase && !flag_ref && !flag_chn)
        |=> (forced_dec && flag_ref && !flag_chn));

    // R10
    valid_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (flag_ref ^ flag_chn));

    // R10
    valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!close_phase || clr_phase) |=> !dec_valid);
endmodule

bind skew_polarity_det skp_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_hit     (ref_hit),
    .chn_hit     (chn_hit),
    .clr_phase   (clr_phase),
    .close_phase (close_phase),
    .flag_ref    (flag_ref),
    .flag_chn    (flag_chn),
    .forced_dec  (forced_dec),
    .dec_valid   (dec_valid)
);

// File: tb/sim_skew_polarity_det.sv
`timescale 1ns/1ps
module sim_skew_polarity_det;

    typedef struct {
        logic  a;
        logic  b;
        logic  f;
        logic  v;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_hit = 1'b0;
    logic chn_hit = 1'b0;
    logic clr_phase = 1'b0;
    logic close_phase = 1'b0;
    logic flag_ref, flag_chn, forced_dec, dec_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t q[$];

    // reference model state built from the requirements
    logic ma = 1'b0, mb = 1'b0, mf = 1'b0, mv = 1'b0;

    always #10 clk = ~clk;

    skew_polarity_det u0 (
        .clk         (clk),
        .rst         (rst),
        .ref_hit     (ref_hit),
        .chn_hit     (chn_hit),
        .clr_phase   (clr_phase),
        .close_phase (close_phase),
        .flag_ref    (flag_ref),
        .flag_chn    (flag_chn),
        .forced_dec  (forced_dec),
        .dec_valid   (dec_valid)
    );

    task automatic drive(input logic rs, input logic r, input logic c,
                         input logic p1, input logic p3, input string tag);
        exp_t e;
        @(negedge clk);
        rst = rs; ref_hit = r; chn_hit = c; clr_phase = p1; close_phase = p3;
        if (rs || p1) begin
            ma = 0; mb = 0; mf = 0; mv = 0;
        end else if (!ma && !mb && !mf && p3) begin
            ma = 1; mb = 0; mf = 1; mv = 1;
        end else if (!ma && !mb && !mf) begin
            if (r && !c) ma = 1;
            if (c && !r) mb = 1;
            mv = 0;
        end else begin
            mv = p3;
        end
        e.a = ma; e.b = mb; e.f = mf; e.v = mv; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (flag_ref !== e.a || flag_chn !== e.b ||
                    forced_dec !== e.f || dec_valid !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: got a=%b b=%b fd=%b v=%b expected a=%b b=%b fd=%b v=%b",
                             e.tag, flag_ref, flag_chn, forced_dec, dec_valid,
                             e.a, e.b, e.f, e.v);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        drive(1, 0, 0, 0, 0, "R1 reset");
        drive(1, 1, 1, 0, 1, "R1 reset with inputs");
        drive(0, 0, 0, 0, 0, "R1 idle after reset");
        drive(0, 1, 0, 1, 0, "R6 ref ignored during clear");
        drive(0, 1, 0, 0, 0, "R2 R7 ref wins after clear");
        drive(0, 0, 1, 0, 0, "R4 late chn locked out");
        drive(0, 0, 0, 0, 1, "R10 close gives valid ref");
        drive(0, 0, 0, 0, 0, "R10 valid is one cycle");
        drive(0, 0, 0, 1, 0, "R6 clear");
        drive(0, 0, 1, 0, 0, "R3 chn wins");
        drive(0, 1, 0, 0, 0, "R4 late ref locked out");
        drive(0, 0, 0, 0, 1, "R10 close gives valid chn");
        drive(0, 0, 0, 1, 0, "R6 clear");
        drive(0, 1, 1, 0, 0, "R5 tie sets nothing");
        drive(0, 0, 0, 0, 0, "R5 still empty");
        drive(0, 0, 0, 0, 1, "R8 forced after tie");
        drive(0, 0, 1, 0, 0, "R9 chn ignored while forced");
        drive(0, 1, 0, 0, 0, "R9 ref ignored while forced");
        drive(0, 0, 0, 0, 1, "R9 R10 second close keeps forced");
        drive(0, 0, 0, 1, 0, "R6 clear ends forced");
        drive(0, 0, 1, 0, 1, "R8 edge with close still forced");
        drive(0, 0, 0, 1, 1, "R6 R10 clear beats close");
        drive(0, 0, 0, 0, 0, "R10 no valid after clear+close");
        drive(0, 0, 1, 0, 0, "R3 R7 chn after clear");
        drive(1, 0, 0, 0, 0, "R1 reset mid acquisition");
        drive(0, 1, 0, 0, 0, "R2 ref after reset");
        drive(0, 0, 0, 0, 0, "R2 hold");
        drive(0, 0, 0, 0, 0, "drain");
        repeat (3) @(posedge clk);
        #6;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule